// File: doc/BRIEF.md
# Machine-Cycle Watchdog with Power-Down Freeze

The block is a watchdog for a small 8-bit controller. It counts machine cycles, marked by a one-clock strobe from the clock generator. If software does not service it before the chosen limit, it requests a chip reset. A 3-bit select value picks one of eight limits, each twice as long as the one before. Software services the watchdog by writing a two-byte key to a dedicated register. The first complete key after reset also starts the watchdog. Once it is running, the select value is locked.

The block tracks the low-power state of the chip. In idle the oscillator still runs, so counting continues as normal. In power-down the counter is frozen. If power-down ends through a level-active external interrupt, the counter stays frozen for as long as that interrupt line (active low) remains low. Counting resumes only when the line returns high. If power-down ends through a hardware reset, the block restarts from its reset state.

Top module: `wdog_pd`

## Requirements
- R1: After reset the select value is 000, the watchdog is stopped, `rst_req` is low and `cfg_rd` reads 0x00. A stopped watchdog never raises `rst_req`.
- R2: While the watchdog is stopped, a write to address 0 stores `wr_data[2:0]` as the select value. `cfg_rd` returns the select value in bits 2:0, and bits 7:3 always read 0.
- R3: With select value n, `rst_req` rises after the (2^(BASE_EXP+n) − 1)-th machine-cycle strobe following the last service. BASE_EXP defaults to 14.
- R4: A write of 0x1E to address 1 followed directly by a write of 0xE1 to address 1 services the watchdog. Servicing clears the count and starts the watchdog if it is stopped.
- R5: Any other write between 0x1E and 0xE1 aborts the key. This covers a write to address 0 and a different byte written to address 1. An aborted key neither starts nor services the watchdog.
- R6: `rst_req` stays high until the next machine-cycle strobe, which lasts one machine cycle. The watchdog is then stopped with a cleared count, and no further request follows without a new service.
- R7: A write to address 0 while the watchdog runs is ignored. `cfg_rd` and the timeout both keep their earlier values.
- R8: The count advances only on clocks where `mc_en` is high.
- R9: While `pdown_i` is high the count does not advance.
- R10: After power-down ends while `ext_int_n` is low, the count stays frozen until `ext_int_n` goes high. It then continues from its frozen value.
- R11: While `idle_i` is high the count keeps advancing, and the timeout is unchanged.
- R12: A reset asserted during power-down returns the block to the R1 state with no wake-up hold pending. After that, counting is not gated by a low `ext_int_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mc_en | input | 1 | Machine-cycle strobe, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 = select register, 1 = service register |
| wr_data | input | 8 | Write data |
| idle_i | input | 1 | Chip is in idle mode |
| pdown_i | input | 1 | Chip is in power-down mode |
| ext_int_n | input | 1 | Level-active external interrupt, active low |
| rst_req | output | 1 | Chip reset request |
| cfg_rd | output | 8 | Select register readback |

## Verification
The service (or the write that sets the select value) takes effect on the clock edge of its write. With the strobe held high, `rst_req` becomes visible after exactly the terminal-count number of further edges. It drops one strobe later. The bench drives inputs and samples outputs on falling edges. It checks that `rst_req` is low one edge before the due edge, high at the due edge, and low at the edge after that. Frozen intervals are excluded from this count, so any freeze that leaks or any early resume shifts the pulse and is caught. A readback after a register write is sampled at the first falling edge after the write edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;
  localparam logic       ADDR_CFG   = 1'b0;
  localparam logic       ADDR_SVC   = 1'b1;

  typedef enum logic [1:0] {
    MD_RUN   = 2'd0,
    MD_IDLE  = 2'd1,
    MD_PDOWN = 2'd2,
    MD_WAKE  = 2'd3
  } wdt_mode_e;
endpackage

// File: rtl/wdt_mode.sv
module wdt_mode
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic pdown_i,
  input  logic ext_int_n,
  output logic freeze_o
);
  logic      hold_q, hold_d;
  wdt_mode_e mode;

  // A wake hold is armed by power-down and released once the interrupt line is high
  always_comb begin
    hold_d = hold_q;
    if (pdown_i)        hold_d = 1'b1;
    else if (ext_int_n) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  always_comb begin
    if (pdown_i)                 mode = MD_PDOWN;
    else if (hold_q && !ext_int_n) mode = MD_WAKE;
    else if (idle_i)             mode = MD_IDLE;
    else                         mode = MD_RUN;
  end

  assign freeze_o = (mode == MD_PDOWN) || (mode == MD_WAKE);
endmodule

// File: rtl/wdt_svc.sv
module wdt_svc
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              kick_o
);
  logic armed_q, armed_d;
  logic svc_wr;

  assign svc_wr = wr_en && (wr_addr == ADDR_SVC);
  assign kick_o = svc_wr && armed_q && (wr_data == DATA_W'(KEY_SECOND));

  always_comb begin
    armed_d = armed_q;
    if (wr_en) armed_d = svc_wr && (wr_data == DATA_W'(KEY_FIRST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 14,
  localparam int NSEL    = 1 << SEL_W,
  localparam int CNT_W   = BASE_EXP + NSEL - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_en,
  input  logic              freeze,
  input  logic              kick,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_req_o,
  output logic [DATA_W-1:0] cfg_rd_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              run_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             run_q, run_d;
  logic             req_q, req_d;
  logic [CNT_W-1:0] last_tab [NSEL];
  logic [CNT_W-1:0] last_val;
  logic             advance, expire;

  // Count value on which the final strobe lands: 2^(BASE_EXP+i) - 2
  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign last_tab[g] = CNT_W'((64'd1 << (BASE_EXP + g)) - 64'd2);
  end

  assign last_val = last_tab[sel_q];
  assign advance  = run_q && mc_en && !freeze;
  assign expire   = advance && (cnt_q == last_val);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    sel_d = sel_q;
    req_d = req_q;
    if (mc_en) req_d = 1'b0;
    if (kick) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (expire) begin
      cnt_d = '0;
      run_d = 1'b0;
      req_d = 1'b1;
    end else if (advance) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (wr_en && (wr_addr == ADDR_CFG) && !run_q) sel_d = wr_data[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      sel_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      sel_q <= sel_d;
      req_q <= req_d;
    end
  end

  assign rst_req_o = req_q;
  assign cfg_rd_o  = {{(DATA_W-SEL_W){1'b0}}, sel_q};
  assign cnt_o     = cnt_q;
  assign run_o     = run_q;
  assign sel_o     = sel_q;
endmodule

// File: rtl/wdog_pd.sv
module wdog_pd
  import wdt_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 14,
  localparam int CNT_W   = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_en,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              idle_i,
  input  logic              pdown_i,
  input  logic              ext_int_n,
  output logic              rst_req,
  output logic [DATA_W-1:0] cfg_rd
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             freeze_w, kick_w, run_w;
  logic [CNT_W-1:0] cnt_w;
  logic [SEL_W-1:0] sel_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wdt_mode u_mode (
    .clk(clk), .rst_n(rst_int_n), .idle_i(idle_i), .pdown_i(pdown_i),
    .ext_int_n(ext_int_n), .freeze_o(freeze_w)
  );

  wdt_svc #(.DATA_W(DATA_W)) u_svc (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .kick_o(kick_w)
  );

  wdt_core #(.DATA_W(DATA_W), .SEL_W(SEL_W), .BASE_EXP(BASE_EXP)) u_core (
    .clk(clk), .rst_n(rst_int_n), .mc_en(mc_en), .freeze(freeze_w),
    .kick(kick_w), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rst_req_o(rst_req), .cfg_rd_o(cfg_rd), .cnt_o(cnt_w), .run_o(run_w),
    .sel_o(sel_w)
  );
endmodule

// File: rtl/wdog_pd_chk.sv
module wdog_pd_chk #(
  parameter int CNT_W = 21,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mc_en,
  input logic             wr_en,
  input logic             wr_addr,
  input logic             idle_i,
  input logic             pdown_i,
  input logic             freeze,
  input logic             rst_req,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [SEL_W-1:0] sel
);
  p_req_one_mc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && mc_en) |=> !rst_req);

  p_stop_on_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (!run && cnt == '0));

  p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && !wr_addr) |=> $stable(sel));

  p_strobe_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_en && !wr_en) |=> $stable(cnt));

  p_pdown_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown_i && !wr_en) |=> $stable(cnt));

  p_wake_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdown_i && freeze && !wr_en) |=> $stable(cnt));

  p_idle_counts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && idle_i && !pdown_i && !freeze && mc_en && !wr_en) |=> (cnt != $past(cnt)));
endmodule

bind wdog_pd wdog_pd_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .mc_en(mc_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .idle_i(idle_i), .pdown_i(pdown_i), .freeze(freeze_w), .rst_req(rst_req),
  .run(run_w), .cnt(cnt_w), .sel(sel_w)
);

// File: tb/test_wdog_pd.sv
module test_wdog_pd;
  localparam int BASE = 6;

  logic       clk, rst_n, mc_en, wr_en, wr_addr, idle_i, pdown_i, ext_int_n;
  logic [7:0] wr_data, cfg_rd;
  logic       rst_req;
  int         n_chk, n_err;

  wdog_pd #(.BASE_EXP(BASE)) i_wdog_pd (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .idle_i(idle_i), .pdown_i(pdown_i), .ext_int_n(ext_int_n),
    .rst_req(rst_req), .cfg_rd(cfg_rd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic service();
    wr(1'b1, 8'h1E);
    wr(1'b1, 8'hE1);
  endtask

  function automatic int tmo(input int sel);
    return (1 << (BASE + sel)) - 1;
  endfunction

  task automatic expect_pulse(input int n, input string tag);
    step(n - 1); chk({tag, " early"}, rst_req, 0);
    step(1);     chk({tag, " due"},   rst_req, 1);
    step(1);     chk({tag, " width"}, rst_req, 0);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (rst_req) hits++;
    end
    chk(tag, hits, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_reset();   // R1
    chk("R1 rst_req", rst_req, 0);
    chk("R1 cfg_rd", cfg_rd, 0);
    expect_quiet(300, "R1 stopped quiet");
  endtask

  task automatic t_cfg();     // R2
    wr(1'b0, 8'hFF); chk("R2 readback ff", cfg_rd, 7);
    wr(1'b0, 8'hA5); chk("R2 readback a5", cfg_rd, 5);
    wr(1'b0, 8'h00); chk("R2 readback 00", cfg_rd, 0);
  endtask

  task automatic t_abort();   // R5
    wr(1'b1, 8'h1E); wr(1'b0, 8'h00); wr(1'b1, 8'hE1);
    expect_quiet(200, "R5 cfg write aborts");
    wr(1'b1, 8'h1E); wr(1'b1, 8'h55); wr(1'b1, 8'hE1);
    expect_quiet(200, "R5 wrong byte aborts");
  endtask

  task automatic t_sel(input int s);  // R3 R4 R6
    wr(1'b0, 8'(s));
    service();
    expect_pulse(tmo(s), "R3 R4 timeout");
    expect_quiet(tmo(s) + 20, "R6 stopped after request");
  endtask

  task automatic t_lock();    // R7
    wr(1'b0, 8'h00);
    service();
    wr(1'b0, 8'h03);
    chk("R7 cfg locked", cfg_rd, 0);
    expect_pulse(tmo(0) - 1, "R7 timeout kept");
  endtask

  task automatic t_kick();    // R4
    service();
    step(40);
    service();
    expect_pulse(tmo(0), "R4 service clears count");
  endtask

  task automatic t_mcen();    // R8
    service();
    mc_en = 1'b0;
    step(150);
    chk("R8 no strobe no request", rst_req, 0);
    mc_en = 1'b1;
    expect_pulse(tmo(0), "R8 strobe counting");
  endtask

  task automatic t_pdown();   // R9
    service();
    step(10);
    pdown_i = 1'b1;
    expect_quiet(300, "R9 frozen in power-down");
    pdown_i = 1'b0;
    expect_pulse(tmo(0) - 10, "R9 resume after power-down");
  endtask

  task automatic t_wake();    // R10
    service();
    step(10);
    pdown_i = 1'b1;
    step(100);
    ext_int_n = 1'b0;
    step(5);
    pdown_i = 1'b0;
    expect_quiet(120, "R10 held while interrupt low");
    ext_int_n = 1'b1;
    expect_pulse(tmo(0) - 10, "R10 resume on interrupt high");
  endtask

  task automatic t_idle();    // R11
    idle_i = 1'b1;
    service();
    expect_pulse(tmo(0), "R11 idle keeps counting");
    idle_i = 1'b0;
  endtask

  task automatic t_hwreset(); // R12
    wr(1'b0, 8'h02);
    service();
    step(10);
    pdown_i = 1'b1;
    ext_int_n = 1'b0;
    step(20);
    rst_n = 1'b0;
    step(2);
    pdown_i = 1'b0;
    step(1);
    rst_n = 1'b1;
    step(4);
    chk("R12 cfg reset", cfg_rd, 0);
    expect_quiet(300, "R12 stopped after reset");
    service();
    expect_pulse(tmo(0), "R12 no wake hold after reset");
    ext_int_n = 1'b1;
  endtask

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; mc_en = 1'b1; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
    idle_i = 1'b0; pdown_i = 1'b0; ext_int_n = 1'b1;
    step(1);
    do_reset();
    t_reset();
    t_cfg();
    t_abort();
    t_sel(0);
    t_sel(1);
    t_sel(3);
    t_lock();
    t_kick();
    t_mcen();
    t_pdown();
    t_wake();
    t_idle();
    t_hwreset();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog: bench timed out, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule